// File: doc/BRIEF.md
# Done Queue Write Pointer Manager

This block keeps track of a circular done queue that lives in host memory. A transmit DMA engine places completion descriptors into the queue, and the host removes them. The block stores the queue's 32-bit base address, a relative end index, the DMA write pointer and the host read pointer. For each descriptor slot the DMA asks for, the block grants the request and returns the absolute dword address of the slot. It then advances the write pointer and wraps it at the end index.

Software sets up the queue through a small register port while the DMA is disabled, and then enables it. While the DMA runs, the host moves its read pointer forward. A slot request is refused while the queue is full, and also while the DMA is disabled. A sticky notification bit tells the host that entries have arrived. The host can program that bit to rise on every write or only once per group of writes.

Top module: `dq_wrptr_mgr`

Register map (`reg_addr`):
- 0: base address bits 15:0
- 1: base address bits 31:16
- 2: end index
- 3: write pointer
- 4: host read pointer
- 5: control. Bit 0 is the DMA enable. Bits 3:1 are the threshold code.
- 6: read-only status. Bit 0 is the notification bit. Bit 1 is the full flag.

Read data comes back on `reg_rdata` one cycle after `reg_addr` is presented.

## Requirements
- R1: The base address is written as two 16-bit halves: register 0 holds the low half and register 1 holds the high half. Both halves read back as written.
- R2: A granted request returns `dma_addr` equal to the base plus four times the write pointer that was current when the request was accepted.
- R3: Each granted request advances the write pointer by one, and the new value reads back from register 3.
- R4: When the write pointer is at or above the end index, the next grant sets it to 0.
- R5: A request is never granted while the enable bit (control bit 0) is clear.
- R6: The queue is full when the wrapped next write pointer equals the host read pointer. While full, `q_full` is 1, status bit 1 is 1, and requests are not granted.
- R7: The threshold code t (control bits 3:1) makes `stat_dqw` rise on every 2^t-th granted write, for t from 0 to 7.
- R8: `stat_dqw` stays set until a `stat_clr` pulse clears it. The clear does not restart the write-group count.
- R9: Writes to the base, end-index and write-pointer registers are ignored while the DMA is enabled. The host read pointer is writable at any time.
- R10: Disabling the DMA restarts the write-group count from zero.
- R11: After reset all registers read 0 and `dma_gnt` and `stat_dqw` are 0. With an end index of 0 the queue reads as full, so status reads 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data for reg_addr |
| dma_req | input | 1 | DMA asks for a done-queue slot |
| dma_gnt | output | 1 | One-cycle grant pulse |
| dma_addr | output | 32 | Absolute address of the granted slot |
| q_full | output | 1 | Queue full |
| stat_dqw | output | 1 | Sticky done-queue-write notification |
| stat_clr | input | 1 | Clears the notification bit |

## Verification
A wrong write pointer shows up on `dma_addr` at the very next grant, and on the register 3 readback one cycle after the read address is presented. A missed wrap or a wrong full comparison shows when the pointer passes the end index: a slot address goes out past the last entry, or a grant appears in the cycle where the queue should stall. A wrong group counter moves the rise of `stat_dqw` off the expected 2^t-th write by one or more grants, and this is seen within a single group.

// File: rtl/dq_pkg.sv
package dq_pkg;
  typedef enum logic [2:0] {
    RS_BASE_LO = 3'd0,
    RS_BASE_HI = 3'd1,
    RS_END     = 3'd2,
    RS_WPTR    = 3'd3,
    RS_RPTR    = 3'd4,
    RS_CTRL    = 3'd5,
    RS_STAT    = 3'd6
  } reg_sel_e;
endpackage

// File: rtl/dq_ptr.sv
module dq_ptr #(
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [PTR_W-1:0] load_val,
  input  logic             adv,
  input  logic [PTR_W-1:0] end_idx,
  output logic [PTR_W-1:0] ptr,
  output logic [PTR_W-1:0] ptr_nxt
);
  always_comb begin
    if (ptr >= end_idx) ptr_nxt = '0;
    else                ptr_nxt = ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)          ptr <= '0;
    else if (adv)     ptr <= ptr_nxt;
    else if (load_en) ptr <= load_val;
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (adv && ptr < end_idx) |=> ptr == $past(ptr) + 1'b1); // R3
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (adv && ptr >= end_idx) |=> ptr == '0); // R4
endmodule

// File: rtl/dq_coalesce.sv
module dq_coalesce #(
  parameter int THR_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [THR_W-1:0] thr,
  input  logic             hit,
  input  logic             clr,
  output logic             stat
);
  localparam int CNT_W = 1 << THR_W;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] cnt_inc;
  logic             fire;

  assign target  = CNT_W'(1) << thr;
  assign cnt_inc = cnt + 1'b1;
  assign fire    = hit && (cnt_inc >= target);

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (fire)  cnt <= '0;
    else if (hit)   cnt <= cnt_inc;
  end

  always_ff @(posedge clk) begin
    if (rst)       stat <= 1'b0;
    else if (fire) stat <= 1'b1;
    else if (clr)  stat <= 1'b0;
  end

  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (stat && !clr) |=> stat); // R8
  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
    !en |=> cnt == '0); // R10
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt < target || !$stable(thr) || $past(!$stable(thr))); // R7
endmodule

// File: rtl/dq_wrptr_mgr.sv
module dq_wrptr_mgr
  import dq_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int THR_W  = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr_en,
  input  logic [2:0]          reg_addr,
  input  logic [HALF_W-1:0]   reg_wdata,
  output logic [HALF_W-1:0]   reg_rdata,
  input  logic                dma_req,
  output logic                dma_gnt,
  output logic [2*HALF_W-1:0] dma_addr,
  output logic                q_full,
  output logic                stat_dqw,
  input  logic                stat_clr
);
  localparam int PTR_W  = HALF_W;
  localparam int ADDR_W = 2 * HALF_W;
  localparam int PAD_W  = ADDR_W - PTR_W - 2;

  logic [HALF_W-1:0] base_lo, base_hi;
  logic [PTR_W-1:0]  end_q, rptr_q, wptr, wptr_nxt;
  logic              en_q;
  logic [THR_W-1:0]  thr_q;
  logic [ADDR_W-1:0] base_q;
  logic              full, accept, cfg_ok, wptr_ld;

  assign base_q = {base_hi, base_lo};
  assign full   = (wptr_nxt == rptr_q);
  assign accept = dma_req && en_q && !full && !dma_gnt;
  assign cfg_ok = reg_wr_en && !en_q;
  assign wptr_ld = cfg_ok && (reg_addr == RS_WPTR);
  assign q_full = full;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_lo <= '0;
      base_hi <= '0;
      end_q   <= '0;
      rptr_q  <= '0;
      en_q    <= 1'b0;
      thr_q   <= '0;
    end else if (reg_wr_en) begin
      if (cfg_ok && reg_addr == RS_BASE_LO) base_lo <= reg_wdata;
      if (cfg_ok && reg_addr == RS_BASE_HI) base_hi <= reg_wdata;
      if (cfg_ok && reg_addr == RS_END)     end_q   <= reg_wdata;
      if (reg_addr == RS_RPTR)              rptr_q  <= reg_wdata;
      if (reg_addr == RS_CTRL) begin
        en_q  <= reg_wdata[0];
        thr_q <= reg_wdata[THR_W:1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dma_gnt  <= 1'b0;
      dma_addr <= '0;
    end else begin
      dma_gnt <= accept;
      if (accept) dma_addr <= base_q + {{PAD_W{1'b0}}, wptr, 2'b00};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        RS_BASE_LO: reg_rdata <= base_lo;
        RS_BASE_HI: reg_rdata <= base_hi;
        RS_END:     reg_rdata <= end_q;
        RS_WPTR:    reg_rdata <= wptr;
        RS_RPTR:    reg_rdata <= rptr_q;
        RS_CTRL:    reg_rdata <= HALF_W'({thr_q, en_q});
        RS_STAT:    reg_rdata <= HALF_W'({full, stat_dqw});
        default:    reg_rdata <= '0;
      endcase
    end
  end

  dq_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst(rst), .load_en(wptr_ld), .load_val(reg_wdata),
    .adv(accept), .end_idx(end_q), .ptr(wptr), .ptr_nxt(wptr_nxt)
  );

  dq_coalesce #(.THR_W(THR_W)) u_coal (
    .clk(clk), .rst(rst), .en(en_q), .thr(thr_q), .hit(accept),
    .clr(stat_clr), .stat(stat_dqw)
  );

  AST_GNT_EN: assert property (@(posedge clk) disable iff (rst)
    dma_gnt |-> $past(en_q)); // R5
  AST_NO_GNT_FULL: assert property (@(posedge clk) disable iff (rst)
    dma_gnt |-> !$past(full)); // R6
  AST_GNT_ADDR: assert property (@(posedge clk) disable iff (rst)
    dma_gnt |-> dma_addr == $past(base_q) + {{PAD_W{1'b0}}, $past(wptr), 2'b00}); // R2
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    $past(en_q) |-> ($stable(base_q) && $stable(end_q))); // R9
endmodule

// File: tb/dq_wrptr_mgr_test.sv
module dq_wrptr_mgr_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        dma_req = 1'b0;
  logic        dma_gnt;
  logic [31:0] dma_addr;
  logic        q_full;
  logic        stat_dqw;
  logic        stat_clr = 1'b0;

  int total = 0;
  int bad = 0;
  logic        g;
  logic [31:0] a;
  logic [15:0] rv;
  localparam logic [31:0] BASE = 32'h8001_A000;

  always #2.5 clk = ~clk;

  dq_wrptr_mgr uut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_req(dma_req),
    .dma_gnt(dma_gnt), .dma_addr(dma_addr), .q_full(q_full),
    .stat_dqw(stat_dqw), .stat_clr(stat_clr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] ad, input logic [15:0] d);
    @(negedge clk); reg_wr_en = 1'b1; reg_addr = ad; reg_wdata = d;
    @(negedge clk); reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] ad, output logic [15:0] d);
    @(negedge clk); reg_addr = ad;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic dw(output logic got, output logic [31:0] ad);
    @(negedge clk); dma_req = 1'b1;
    @(negedge clk); got = dma_gnt; ad = dma_addr; dma_req = 1'b0;
  endtask

  task automatic clr();
    @(negedge clk); stat_clr = 1'b1;
    @(negedge clk); stat_clr = 1'b0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 6; i++) begin rd(3'(i), rv); check("R11 reg", rv, 0); end
    rd(3'd6, rv); check("R11 stat", rv, 16'h2);
    check("R11 gnt", dma_gnt, 0);
    check("R11 stat_dqw", stat_dqw, 0);
  endtask

  task automatic t_regs();
    wr(3'd0, 16'hA000); wr(3'd1, 16'h8001); wr(3'd2, 16'd5);
    rd(3'd0, rv); check("R1 lo", rv, 16'hA000);
    rd(3'd1, rv); check("R1 hi", rv, 16'h8001);
  endtask

  task automatic t_basic();
    wr(3'd5, 16'h1);
    for (int i = 0; i < 3; i++) begin
      dw(g, a);
      check("R2 gnt", g, 1);
      check("R2 addr", a, BASE + 32'(i * 4));
      check("R7 every write", stat_dqw, 1);
      clr();
      check("R8 cleared", stat_dqw, 0);
    end
    rd(3'd3, rv); check("R3 wptr", rv, 3);
  endtask

  task automatic t_ignore();
    wr(3'd0, 16'hFFFF); wr(3'd2, 16'd9); wr(3'd3, 16'd7);
    rd(3'd0, rv); check("R9 base", rv, 16'hA000);
    rd(3'd2, rv); check("R9 end", rv, 5);
    rd(3'd3, rv); check("R9 wptr", rv, 3);
  endtask

  task automatic t_wrap();
    wr(3'd4, 16'd3);
    rd(3'd4, rv); check("R9 rptr live", rv, 3);
    for (int i = 3; i <= 5; i++) begin
      dw(g, a); check("R4 addr", a, BASE + 32'(i * 4));
    end
    rd(3'd3, rv); check("R4 wrapped", rv, 0);
    dw(g, a); check("R4 addr0", a, BASE);
    dw(g, a); check("R4 addr1", a, BASE + 4);
    check("R6 q_full", q_full, 1);
    rd(3'd6, rv); check("R6 stat full", rv & 16'h2, 16'h2);
    dw(g, a); check("R6 no gnt", g, 0);
    rd(3'd3, rv); check("R6 wptr held", rv, 2);
  endtask

  task automatic t_disable();
    wr(3'd4, 16'd100); wr(3'd5, 16'h0);
    check("R5 not full", q_full, 0);
    dw(g, a); check("R5 no gnt", g, 0);
    rd(3'd3, rv); check("R5 wptr held", rv, 2);
  endtask

  task automatic t_coalesce();
    wr(3'd2, 16'd1000); wr(3'd3, 16'd0); wr(3'd4, 16'd500);
    wr(3'd5, 16'h5); clr();
    for (int i = 0; i < 3; i++) dw(g, a);
    check("R7 group of 4 early", stat_dqw, 0);
    dw(g, a); check("R7 group of 4", stat_dqw, 1);
    dw(g, a); check("R8 sticky", stat_dqw, 1);
    clr();
    dw(g, a); dw(g, a); check("R8 count kept early", stat_dqw, 0);
    dw(g, a); check("R8 count kept", stat_dqw, 1);
    clr();
    dw(g, a); dw(g, a);
    wr(3'd5, 16'h0); wr(3'd5, 16'h5);
    for (int i = 0; i < 3; i++) dw(g, a);
    check("R10 restart", stat_dqw, 0);
    dw(g, a); check("R10 group after restart", stat_dqw, 1);
    rd(3'd3, rv); check("R3 wptr count", rv, 14);
  endtask

  task automatic t_max();
    wr(3'd5, 16'h0); wr(3'd3, 16'd0); wr(3'd5, 16'hF); clr();
    for (int i = 0; i < 127; i++) dw(g, a);
    check("R7 128 early", stat_dqw, 0);
    dw(g, a); check("R7 128", stat_dqw, 1);
    check("R2 addr 127", a, BASE + 32'(127 * 4));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_basic();
    t_ignore();
    t_wrap();
    t_disable();
    t_coalesce();
    t_max();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule